// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store placed beside a direct-mapped or low-associativity primary data cache. It catches whole lines that the primary cache throws out. When the primary cache later misses, it asks this buffer first. If the buffer holds the line, the line goes straight back to the primary cache and no lower-level access is made. Only a buffer miss turns into a fetch from the next level. Conflict victims that bounce between two addresses therefore never leave the chip.

Each slot holds a valid flag, a tag, a dirty flag and a line of four 32-bit words. The tag is the full line address without the 4-bit byte offset. Slots are filled only from the eviction port. When all slots are occupied, the slot written longest ago is overwritten. If that slot is dirty, its contents are sent to the lower level as a write request.

A lookup may carry the line that the primary cache is displacing. On a hit, that line is put in the slot of the line being returned, so the two lines trade places. A single request port to the lower level carries both line reads (after a buffer miss) and write-backs (of a dirty line pushed out). A request is held until the lower level acknowledges it. While a request is outstanding, the buffer reports itself not ready.

Top module: `victim_cache`

## Requirements
- R1: After reset every slot is invalid, `ready` is 1, and both `rspValid` and `memReqValid` are 0. Because the slots are invalid, a lookup of tag 0 right after reset misses.
- R2: A lookup accepted at a clock edge (`lkValid` with `ready` high) gives `rspValid`=1 for exactly one cycle after that edge. In that cycle, `rspHit` is 1 exactly when a valid slot holds a tag equal to all 28 bits of `lkTag`.
- R3: On a hit, the response carries that slot's stored 128-bit line and dirty flag, and no lower-level request is raised.
- R4: On a miss, a read request is raised in the response cycle: `memReqWrite`=0 and `memReqAddr` = `{lkTag, 4'b0000}`. The request stays raised with stable fields until a cycle with `memAck`=1.
- R5: On a hit with `dispValid`=1, the displaced line (tag, data and dirty flag) takes over the hit slot, and the returned tag no longer hits. With `dispValid`=0, the hit slot becomes invalid.
- R6: Insertions go into slots in a fixed rotation starting at slot 0, one step per insertion. The ninth insertion therefore overwrites the line inserted first, which then misses, while the others still hit.
- R7: If an insertion overwrites a valid dirty slot, a write request is raised one cycle later. It carries `memReqWrite`=1, that line's `{tag, 4'b0000}` address and its data, and it is held until `memAck`. Overwriting a clean or invalid slot raises no request.
- R8: While a request is outstanding, `ready` is 0. Lookups and insertions offered in that time are ignored: they produce no response and change no slot.
- R9: If a lookup and an insertion are offered in the same cycle, the lookup is served and the insertion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Evicted line offered for insertion |
| evTag | input | 28 | Line address of the evicted line |
| evDirty | input | 1 | Evicted line is modified |
| evData | input | 128 | Evicted line contents |
| lkValid | input | 1 | Lookup after a primary miss |
| lkTag | input | 28 | Line address looked up |
| dispValid | input | 1 | A displaced primary line comes with the lookup |
| dispTag | input | 28 | Displaced line address |
| dispDirty | input | 1 | Displaced line is modified |
| dispData | input | 128 | Displaced line contents |
| ready | output | 1 | No lower-level request outstanding |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup found the line |
| rspDirty | output | 1 | Returned line is modified |
| rspData | output | 128 | Returned line contents |
| memReqValid | output | 1 | Lower-level request pending |
| memReqWrite | output | 1 | 1 = write-back, 0 = line read |
| memReqAddr | output | 32 | Request byte address, line aligned |
| memReqData | output | 128 | Write-back line contents |
| memAck | input | 1 | Lower level accepts the pending request |

## Verification
The bench goes after the following corner cases:
- A buffer that swaps on a hit but forgets to install the displaced line would lose it, and a later lookup of that line would miss.
- A buffer that installs it without clearing the old tag would return stale data.
- The ninth insertion must evict exactly the oldest line. A wrong rotation would drop a younger line instead. A bad dirty test would either lose modified data or write back clean lines.
- Requests are held through several unacknowledged cycles, and a lookup is offered while the buffer is busy. A design that drops a request early, or accepts work while busy, produces stray responses or corrupts slot contents.
- A lookup and an insertion arrive together. A design that takes both would make the dropped line visible later.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // strobes from control to datapath, all for the current clock edge
  typedef struct packed {
    logic doInsert;   // write evicted line into rotation slot
    logic doSwap;     // replace hit slot with displaced line
    logic loadWb;     // latch rotation slot as write-back request
    logic loadRd;     // latch lookup address as read request
    logic capRsp;     // capture lookup result
  } vc_strobe_t;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_READ  = 2'd1,
    PEND_WRITE = 2'd2
  } vc_pend_e;

endpackage

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 28,
  parameter int OFF_W   = 4,
  parameter int LINE_W  = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  vc_strobe_t               strobe,
  input  logic [IDX_W-1:0]         ptr,
  input  logic [TAG_W-1:0]         lkTag,
  input  logic                     dispValid,
  input  logic [TAG_W-1:0]         dispTag,
  input  logic                     dispDirty,
  input  logic [LINE_W-1:0]        dispData,
  input  logic [TAG_W-1:0]         evTag,
  input  logic                     evDirty,
  input  logic [LINE_W-1:0]        evData,
  output logic                     hitAny,
  output logic                     slotValid,
  output logic                     slotDirty,
  output logic [LINE_W-1:0]        rspData,
  output logic                     rspDirty,
  output logic [TAG_W+OFF_W-1:0]   reqAddr,
  output logic [LINE_W-1:0]        reqData
);

  localparam int ADDR_W = TAG_W + OFF_W;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ   [ENTRIES];
  logic               dirtyQ [ENTRIES];
  logic [LINE_W-1:0]  dataQ  [ENTRIES];

  logic [ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]   hitIdx;

  // parallel tag compare across all slots
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign hitVec[g] = validQ[g] && (tagQ[g] == lkTag);
  end

  assign hitAny = |hitVec;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign slotValid = validQ[ptr];
  assign slotDirty = dirtyQ[ptr];

  // valid flags and registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= '0;
      rspData  <= '0;
      rspDirty <= 1'b0;
      reqAddr  <= '0;
      reqData  <= '0;
    end else begin
      if (strobe.doSwap)   validQ[hitIdx] <= dispValid;
      if (strobe.doInsert) validQ[ptr]    <= 1'b1;
      if (strobe.capRsp) begin
        rspData  <= hitAny ? dataQ[hitIdx] : '0;
        rspDirty <= hitAny && dirtyQ[hitIdx];
      end
      if (strobe.loadRd) begin
        reqAddr <= {lkTag, {OFF_W{1'b0}}};
        reqData <= '0;
      end else if (strobe.loadWb) begin
        reqAddr <= {tagQ[ptr], {OFF_W{1'b0}}};
        reqData <= dataQ[ptr];
      end
    end
  end

  // slot payload, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.doSwap) begin
      tagQ[hitIdx]   <= dispTag;
      dirtyQ[hitIdx] <= dispDirty;
      dataQ[hitIdx]  <= dispData;
    end
    if (strobe.doInsert) begin
      tagQ[ptr]   <= evTag;
      dirtyQ[ptr] <= evDirty;
      dataQ[ptr]  <= evData;
    end
  end

  // at most one slot may match a given line address
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // an insertion leaves its slot valid
  assert_insert_fills_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doInsert |=> validQ[$past(ptr)]);

  // a write-back request names the line that was in the slot
  assert_wb_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWb |=> reqAddr[ADDR_W-1:OFF_W] == $past(tagQ[ptr]));

endmodule

// File: rtl/vc_control.sv
module vc_control
  import vc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic             lkValid,
  input  logic             hitAny,
  input  logic             slotValid,
  input  logic             slotDirty,
  input  logic             memAck,
  output vc_strobe_t       strobe,
  output logic [IDX_W-1:0] ptr,
  output logic             ready,
  output logic             rspValid,
  output logic             rspHit,
  output logic             memReqValid,
  output logic             memReqWrite
);

  vc_pend_e pendQ;
  logic     lkGo;
  logic     evGo;

  assign ready = (pendQ == PEND_NONE);
  assign lkGo  = lkValid && ready;
  assign evGo  = evValid && ready && !lkValid;   // lookup wins a collision

  always_comb begin
    strobe          = '0;
    strobe.capRsp   = lkGo;
    strobe.doSwap   = lkGo && hitAny;
    strobe.loadRd   = lkGo && !hitAny;
    strobe.doInsert = evGo;
    strobe.loadWb   = evGo && slotValid && slotDirty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= PEND_NONE;
      ptr      <= '0;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= lkGo;
      rspHit   <= lkGo && hitAny;
      if (evGo) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      if (pendQ != PEND_NONE) begin
        if (memAck) pendQ <= PEND_NONE;
      end else if (strobe.loadRd) begin
        pendQ <= PEND_READ;
      end else if (strobe.loadWb) begin
        pendQ <= PEND_WRITE;
      end
    end
  end

  assign memReqValid = (pendQ != PEND_NONE);
  assign memReqWrite = (pendQ == PEND_WRITE);

  assert_rsp_next_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && ready |=> rspValid);

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> !rspValid);

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memAck |=> memReqValid && (memReqWrite == $past(memReqWrite)));

endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               evValid,
  input  logic [ADDR_W-$clog2(LINE_WORDS*WORD_W/8)-1:0] evTag,
  input  logic                               evDirty,
  input  logic [LINE_WORDS*WORD_W-1:0]       evData,
  input  logic                               lkValid,
  input  logic [ADDR_W-$clog2(LINE_WORDS*WORD_W/8)-1:0] lkTag,
  input  logic                               dispValid,
  input  logic [ADDR_W-$clog2(LINE_WORDS*WORD_W/8)-1:0] dispTag,
  input  logic                               dispDirty,
  input  logic [LINE_WORDS*WORD_W-1:0]       dispData,
  output logic                               ready,
  output logic                               rspValid,
  output logic                               rspHit,
  output logic                               rspDirty,
  output logic [LINE_WORDS*WORD_W-1:0]       rspData,
  output logic                               memReqValid,
  output logic                               memReqWrite,
  output logic [ADDR_W-1:0]                  memReqAddr,
  output logic [LINE_WORDS*WORD_W-1:0]       memReqData,
  input  logic                               memAck
);

  localparam int OFF_W  = $clog2(LINE_WORDS * WORD_W / 8);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int LINE_W = LINE_WORDS * WORD_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vc_strobe_t       strobe;
  logic [IDX_W-1:0] ptr;
  logic             hitAny;
  logic             slotValid;
  logic             slotDirty;

  vc_control #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .lkValid(lkValid),
    .hitAny(hitAny), .slotValid(slotValid), .slotDirty(slotDirty),
    .memAck(memAck), .strobe(strobe), .ptr(ptr), .ready(ready),
    .rspValid(rspValid), .rspHit(rspHit),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite)
  );

  vc_datapath #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
                .OFF_W(OFF_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptr(ptr), .lkTag(lkTag),
    .dispValid(dispValid), .dispTag(dispTag), .dispDirty(dispDirty),
    .dispData(dispData), .evTag(evTag), .evDirty(evDirty), .evData(evData),
    .hitAny(hitAny), .slotValid(slotValid), .slotDirty(slotDirty),
    .rspData(rspData), .rspDirty(rspDirty),
    .reqAddr(memReqAddr), .reqData(memReqData)
  );

  // a buffer hit never goes to the lower level
  assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> !memReqValid);

  // a buffer miss always starts a line read
  assert_miss_fetch_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit |-> memReqValid && !memReqWrite);

  // request fields stay put until accepted
  assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memAck |=> $stable(memReqAddr) && $stable(memReqData));

endmodule

// File: tb/victim_cache_bench.sv
module victim_cache_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int TW   = 28;
  localparam int LW   = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evValid = 1'b0;
  logic [TW-1:0] evTag = '0;
  logic          evDirty = 1'b0;
  logic [LW-1:0] evData = '0;
  logic          lkValid = 1'b0;
  logic [TW-1:0] lkTag = '0;
  logic          dispValid = 1'b0;
  logic [TW-1:0] dispTag = '0;
  logic          dispDirty = 1'b0;
  logic [LW-1:0] dispData = '0;
  logic          memAck = 1'b0;
  logic          ready, rspValid, rspHit, rspDirty;
  logic [LW-1:0] rspData;
  logic          memReqValid, memReqWrite;
  logic [31:0]   memReqAddr;
  logic [LW-1:0] memReqData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  victim_cache u_victim_cache (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evTag(evTag),
    .evDirty(evDirty), .evData(evData), .lkValid(lkValid), .lkTag(lkTag),
    .dispValid(dispValid), .dispTag(dispTag), .dispDirty(dispDirty),
    .dispData(dispData), .ready(ready), .rspValid(rspValid),
    .rspHit(rspHit), .rspDirty(rspDirty), .rspData(rspData),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memAck(memAck)
  );

  typedef struct {
    bit            hit;
    bit            dirty;
    logic [LW-1:0] data;
    string         req;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  // bench-side model of the slots
  bit            mValid [N];
  logic [TW-1:0] mTag   [N];
  bit            mDirty [N];
  logic [LW-1:0] mData  [N];
  int            mPtr = 0;

  function automatic logic [LW-1:0] lineOf(input logic [TW-1:0] t);
    logic [31:0] w;
    w = {4'h0, t};
    return {w ^ 32'h1111_0000, w ^ 32'h2222_0000, w ^ 32'h3333_0000, w ^ 32'h4444_0000};
  endfunction

  task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // monitor: pops expected lookup results as responses appear
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 response with no accepted lookup", LW'(rspValid), '0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(rspHit == e.hit, {e.req, " R2 hit flag"}, LW'(rspHit), LW'(e.hit));
        if (e.hit) begin
          check(rspData == e.data, {e.req, " R3 line data"}, rspData, e.data);
          check(rspDirty == e.dirty, {e.req, " R3 dirty"}, LW'(rspDirty), LW'(e.dirty));
        end
      end
    end
  end

  // hold a request several cycles, then acknowledge it
  task automatic serveReq(input bit wr, input logic [31:0] addr,
                          input logic [LW-1:0] data, input string req);
    repeat (2) begin
      @(negedge clk);
      check(memReqValid && memReqWrite == wr && memReqAddr == addr, {req, " held"},
            LW'(memReqAddr), LW'(addr));
      if (wr) check(memReqData == data, {req, " held data"}, memReqData, data);
    end
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    check(!memReqValid && ready, {req, " released"}, LW'({memReqValid, ready}), LW'(2'b01));
  endtask

  task automatic doLookup(input logic [TW-1:0] t, input bit dv, input logic [TW-1:0] dt,
                          input bit dd, input bit withEv, input logic [TW-1:0] et,
                          input string req);
    int idx;
    exp_t e;
    idx = -1;
    for (int i = 0; i < N; i++) if (mValid[i] && mTag[i] == t) idx = i;
    e.hit = (idx >= 0);
    e.dirty = (idx >= 0) ? mDirty[idx] : 1'b0;
    e.data = (idx >= 0) ? mData[idx] : '0;
    e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    lkValid = 1'b1; lkTag = t;
    dispValid = dv; dispTag = dt; dispDirty = dd; dispData = lineOf(dt);
    if (withEv) begin
      evValid = 1'b1; evTag = et; evDirty = 1'b1; evData = lineOf(et);
    end
    @(negedge clk);
    lkValid = 1'b0; dispValid = 1'b0; evValid = 1'b0;
    if (idx >= 0) begin
      check(!memReqValid, {req, " R3 no fetch on hit"}, LW'(memReqValid), '0);
      mValid[idx] = dv; mTag[idx] = dt; mDirty[idx] = dd; mData[idx] = lineOf(dt);
    end else begin
      check(memReqValid && !memReqWrite && memReqAddr == {t, 4'h0},
            {req, " R4 read request"}, LW'(memReqAddr), LW'({t, 4'h0}));
      check(!ready, {req, " R8 busy during read"}, LW'(ready), '0);
      serveReq(1'b0, {t, 4'h0}, '0, {req, " R4"});
    end
  endtask

  task automatic doInsert(input logic [TW-1:0] t, input bit d, input string req);
    int slot;
    bit wb;
    logic [TW-1:0] oTag;
    logic [LW-1:0] oData;
    slot = mPtr;
    wb = mValid[slot] && mDirty[slot];
    oTag = mTag[slot];
    oData = mData[slot];
    @(negedge clk);
    evValid = 1'b1; evTag = t; evDirty = d; evData = lineOf(t);
    @(negedge clk);
    evValid = 1'b0;
    if (wb) begin
      check(memReqValid && memReqWrite && memReqAddr == {oTag, 4'h0} && memReqData == oData,
            {req, " R7 write-back of dirty victim"}, memReqData, oData);
      // offer a lookup while busy: must be dropped
      lkValid = 1'b1; lkTag = 28'h777; dispValid = 1'b1; dispTag = 28'h999;
      dispData = lineOf(28'h999);
      @(negedge clk);
      lkValid = 1'b0; dispValid = 1'b0;
      check(!rspValid && !ready, "R8 lookup ignored while busy", LW'(rspValid), '0);
      serveReq(1'b1, {oTag, 4'h0}, oData, "R7");
    end else begin
      check(!memReqValid, {req, " R7 no request for clean victim"}, LW'(memReqValid), '0);
    end
    mValid[slot] = 1'b1; mTag[slot] = t; mDirty[slot] = d; mData[slot] = lineOf(t);
    mPtr = (mPtr + 1) % N;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 1'b0; mTag[i] = '0; mDirty[i] = 1'b0; mData[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(ready && !rspValid && !memReqValid, "R1 reset state",
          LW'({ready, rspValid, memReqValid}), LW'(3'b100));
    doLookup(28'h0, 1'b0, '0, 1'b0, 1'b0, '0, "R1 empty miss");

    for (int i = 0; i < N; i++) doInsert(28'h100 + TW'(i), i[0], "R6 fill");
    for (int i = 0; i < N; i++)
      doLookup(28'h100 + TW'(i), 1'b1, 28'h200 + TW'(i), ~i[0], 1'b0, '0, "R5 swap");
    doLookup(28'h100, 1'b0, '0, 1'b0, 1'b0, '0, "R5 returned line gone");
    doLookup(28'h203, 1'b0, '0, 1'b0, 1'b0, '0, "R5 displaced line present");
    doLookup(28'h203, 1'b0, '0, 1'b0, 1'b0, '0, "R5 slot invalidated");

    for (int i = 0; i < 10; i++) doInsert(28'h300 + TW'(i), i[0], "R6 rotate");
    doLookup(28'h300, 1'b0, '0, 1'b0, 1'b0, '0, "R6 oldest evicted");
    doLookup(28'h309, 1'b1, 28'h409, 1'b0, 1'b0, '0, "R6 newest present");
    doLookup(28'h302, 1'b1, 28'h402, 1'b1, 1'b0, '0, "R6 middle present");

    doLookup(28'h305, 1'b1, 28'h605, 1'b0, 1'b1, 28'h500, "R9 collision lookup");
    doLookup(28'h500, 1'b0, '0, 1'b0, 1'b0, '0, "R9 insertion dropped");
    doLookup(28'h605, 1'b1, 28'h705, 1'b0, 1'b0, '0, "R5 after collision");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all responses seen", LW'(expQ.size()), '0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule